// File: doc/BRIEF.md
# Paged Address Translator

This block widens a 16-bit processor address into a 24-bit physical address by paging. The logical address space is split into sixteen 4 KB pages. The top four logical bits pick one of sixteen 12-bit page-table entries, and that entry becomes the upper twelve bits of the physical address. The low twelve bits pass through as they are. The result is registered, so a logical address presented before a clock edge appears translated just after that edge.

Software fills the table through a byte-wide register port. A table chip select reaches three offsets: an entry index register, the low byte of the selected entry and the high nibble of the selected entry. A separate control chip select writes the control word. Its only defined bit is the translation enable. While translation is off, the block forms an identity map over the low 64 KB. A reset turns translation off and clears the index register, but it leaves every page-table entry as it was, so software can switch translation back on without reloading the table.

Top module: `page_mapper`

## Requirements
- R1: With translation enabled, `phys_addr[23:12]` on the cycle after a clock edge equals the table entry selected by `log_addr[15:12]` as sampled at that edge.
- R2: `phys_addr[11:0]` on the cycle after a clock edge equals `log_addr[11:0]` sampled at that edge, in every mode.
- R3: With translation disabled, `phys_addr[23:16]` is zero and `phys_addr[15:12]` equals the sampled `log_addr[15:12]`.
- R4: A write with `cs_table` at offset 0 loads `wr_data[3:0]` into the index register. Offset 1 writes `wr_data[7:0]` to bits [7:0] of the indexed entry, and offset 2 writes `wr_data[3:0]` to bits [11:8]. Each part leaves the other part unchanged.
- R5: A write with `cs_ctrl`, at any offset, sets the enable to `wr_data[0]`. Bits [7:1] have no effect.
- R6: While `rst` is high at an edge, the enable, the index register, `phys_addr` and `rd_data` become zero. Page-table contents are kept.
- R7: A read (`rd_en`) registers `rd_data` for the next cycle. With `cs_ctrl` it returns `{7'b0, enable}`. With `cs_table` at offset 0 it returns `{4'b0, index}`. Otherwise, and on cycles without a read, it returns zero.
- R8: Nothing changes state unless `wr_en` is high with a chip select. A table write at offset 3 changes nothing.
- R9: A table or control write takes effect for translations sampled at the following edge and later. A translation sampled at the same edge as the write uses the old state.

Each register access also selects an offset with `reg_addr`: 0 is the index register, 1 is the entry low byte, 2 is the entry high nibble and 3 is unused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| rd_en | input | 1 | Read strobe for the register port |
| cs_table | input | 1 | Selects the index register and the entry halves |
| cs_ctrl | input | 1 | Selects the control word |
| reg_addr | input | 2 | Register offset: 0 index, 1 low byte, 2 high nibble, 3 unused |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| log_addr | input | 16 | Logical address from the processor |
| phys_addr | output | 24 | Registered physical address |

## Verification
The assertions assume the register port is driven with stable, defined values for the whole cycle around each edge. They also assume the checks that compare against the previous cycle's inputs start only once reset is low. The bench keeps within this by changing every input on the falling clock edge. It raises `wr_en` and `rd_en` for one cycle per access, and it holds reset for several full cycles. The bench also writes all sixteen table entries before it relies on their contents, because the entry storage has no reset.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // Register offsets decoded under the table chip select.
  typedef enum logic [1:0] {
    OFF_INDEX = 2'd0,
    OFF_LANE0 = 2'd1,
    OFF_LANE1 = 2'd2,
    OFF_SPARE = 2'd3
  } pm_off_e;

  // Number of byte lanes needed to cover an entry of the given width.
  function automatic int lane_count(input int ent_w, input int bus_w);
    return (ent_w + bus_w - 1) / bus_w;
  endfunction

  // Width of a given lane; the last lane may be narrower than the bus.
  function automatic int lane_width(input int ent_w, input int bus_w, input int lane);
    int rem;
    rem = ent_w - lane * bus_w;
    return (rem < bus_w) ? rem : bus_w;
  endfunction

endpackage

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int RA_W  = 2,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             cs_table,
  input  logic             cs_ctrl,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic             en_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [BUS_W-1:0] rd_q
);

  logic idx_hit;
  logic ctl_wr;
  logic [BUS_W-1:0] rd_next;

  assign idx_hit = cs_table && (reg_addr == RA_W'(OFF_INDEX));
  assign ctl_wr  = wr_en && cs_ctrl;

  // Control word: only bit 0 is stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q <= wr_data[0];
    end
  end

  // Entry index register.
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (wr_en && idx_hit) begin
      idx_q <= wr_data[IDX_W-1:0];
    end
  end

  // Read mux; control select takes priority.
  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      if (cs_ctrl) begin
        rd_next = BUS_W'(en_q);
      end else if (idx_hit) begin
        rd_next = BUS_W'(idx_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_next;
    end
  end

endmodule

// File: rtl/pm_table.sv
module pm_table
  import pm_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int RA_W  = 2,
  parameter int IDX_W = 4,
  parameter int ENT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             cs_table,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] ent_q
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int LANES = lane_count(ENT_W, BUS_W);

  logic tbl_wr;
  assign tbl_wr = wr_en && cs_table && !rst;

  // One narrow RAM per byte lane, each with its own write offset and a
  // read-first synchronous read port driven by the logical page index.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LW = lane_width(ENT_W, BUS_W, l);
    localparam int LO = l * BUS_W;

    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] rd_lane;
    logic          lane_sel;

    assign lane_sel = (reg_addr == RA_W'(int'(OFF_LANE0) + l));

    always_ff @(posedge clk) begin
      if (tbl_wr && lane_sel) begin
        mem[wr_idx] <= wr_data[LW-1:0];
      end
      rd_lane <= mem[rd_idx];
    end

    assign ent_q[LO +: LW] = rd_lane;
  end

endmodule

// File: rtl/pm_xlate.sv
module pm_xlate #(
  parameter int LA_W    = 16,
  parameter int PG_BITS = 12,
  parameter int PA_W    = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [LA_W-1:0]           log_addr,
  input  logic [PA_W-PG_BITS-1:0]   ent_q,
  output logic [PA_W-1:0]           phys_addr
);

  localparam int IDX_W = LA_W - PG_BITS;
  localparam int ENT_W = PA_W - PG_BITS;

  logic               en_d;
  logic [IDX_W-1:0]   page_d;
  logic [PG_BITS-1:0] off_d;
  logic [ENT_W-1:0]   frame;

  // Stage aligned with the table's registered read.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      page_d <= '0;
      off_d  <= '0;
    end else begin
      en_d   <= en;
      page_d <= log_addr[LA_W-1:PG_BITS];
      off_d  <= log_addr[PG_BITS-1:0];
    end
  end

  // Identity map zero-extends the page number when translation is off.
  assign frame     = en_d ? ent_q : ENT_W'(page_d);
  assign phys_addr = {frame, off_d};

endmodule

// File: rtl/page_mapper.sv
module page_mapper #(
  parameter int LA_W    = 16,
  parameter int PA_W    = 24,
  parameter int PG_BITS = 12,
  parameter int BUS_W   = 8,
  parameter int RA_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             cs_table,
  input  logic             cs_ctrl,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  input  logic [LA_W-1:0]  log_addr,
  output logic [PA_W-1:0]  phys_addr
);

  localparam int IDX_W = LA_W - PG_BITS;
  localparam int ENT_W = PA_W - PG_BITS;

  logic             en_w;
  logic [IDX_W-1:0] idx_w;
  logic [ENT_W-1:0] ent_w;

  pm_regs #(.BUS_W(BUS_W), .RA_W(RA_W), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .cs_table (cs_table),
    .cs_ctrl  (cs_ctrl),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .en_q     (en_w),
    .idx_q    (idx_w),
    .rd_q     (rd_data)
  );

  pm_table #(.BUS_W(BUS_W), .RA_W(RA_W), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .cs_table (cs_table),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .wr_idx   (idx_w),
    .rd_idx   (log_addr[LA_W-1:PG_BITS]),
    .ent_q    (ent_w)
  );

  pm_xlate #(.LA_W(LA_W), .PG_BITS(PG_BITS), .PA_W(PA_W)) u_xlate (
    .clk       (clk),
    .rst       (rst),
    .en        (en_w),
    .log_addr  (log_addr),
    .ent_q     (ent_w),
    .phys_addr (phys_addr)
  );

endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
  parameter int LA_W    = 16,
  parameter int PA_W    = 24,
  parameter int PG_BITS = 12,
  parameter int BUS_W   = 8,
  parameter int RA_W    = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic                      cs_table,
  input logic                      cs_ctrl,
  input logic [RA_W-1:0]           reg_addr,
  input logic [BUS_W-1:0]          wr_data,
  input logic [BUS_W-1:0]          rd_data,
  input logic [LA_W-1:0]           log_addr,
  input logic [PA_W-1:0]           phys_addr,
  input logic                      en_state,
  input logic [LA_W-PG_BITS-1:0]   idx_state
);

  localparam int IDX_W = LA_W - PG_BITS;

  logic seen_q = 1'b0;
  logic rst_q  = 1'b0;

  always_ff @(posedge clk) begin
    seen_q <= 1'b1;
    rst_q  <= rst;
    // Outputs were cleared by the previous reset edge (R6).
    if (seen_q && rst_q) begin
      p_reset_clear_r6: assert (phys_addr == '0 && rd_data == '0 && !en_state)
        else $error("reset did not clear outputs");
    end
  end

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phys_addr[PG_BITS-1:0] == $past(log_addr[PG_BITS-1:0]));

  p_identity_map_r3: assert property (@(posedge clk) disable iff (rst)
    !en_state |=> (phys_addr[PA_W-1:LA_W] == '0 &&
                   phys_addr[LA_W-1:PG_BITS] == $past(log_addr[LA_W-1:PG_BITS])));

  p_index_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cs_table && reg_addr == RA_W'(0)) |=> idx_state == $past(wr_data[IDX_W-1:0]));

  p_enable_load_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cs_ctrl) |=> en_state == $past(wr_data[0]));

  p_ctrl_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cs_ctrl) |=> rd_data == BUS_W'($past(en_state)));

  p_idle_read_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);

  p_enable_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && cs_ctrl) |=> $stable(en_state));

endmodule

bind page_mapper pm_checker #(
  .LA_W(LA_W), .PA_W(PA_W), .PG_BITS(PG_BITS), .BUS_W(BUS_W), .RA_W(RA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .cs_table  (cs_table),
  .cs_ctrl   (cs_ctrl),
  .reg_addr  (reg_addr),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .log_addr  (log_addr),
  .phys_addr (phys_addr),
  .en_state  (en_w),
  .idx_state (idx_w)
);

// File: tb/sim_page_mapper.sv
`timescale 1ns/1ps
module sim_page_mapper;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, cs_table = 1'b0, cs_ctrl = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [15:0] log_addr = '0;
  logic [23:0] phys_addr;

  always #2.5 clk = ~clk;

  page_mapper u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .cs_table(cs_table),
    .cs_ctrl(cs_ctrl), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .log_addr(log_addr), .phys_addr(phys_addr)
  );

  int tests = 0;
  int fails = 0;
  string phase = "R6";

  // Behavioural reference state.
  int tbl [16];
  int m_en = 0, m_idx = 0;
  int exp_phys = 0, exp_rd = 0;
  bit exp_valid = 0, exp_rst = 0, exp_on = 0;

  initial for (int i = 0; i < 16; i++) tbl[i] = 0;

  always @(posedge clk) begin
    int pg;
    pg = log_addr[15:12];
    exp_valid = 1;
    exp_rst   = rst;
    if (rst) begin
      exp_phys = 0; exp_rd = 0; m_en = 0; m_idx = 0; exp_on = 0;
    end else begin
      exp_on   = (m_en != 0);
      exp_phys = exp_on ? ((tbl[pg] << 12) | log_addr[11:0]) : log_addr;
      exp_rd   = 0;
      if (rd_en) begin
        if (cs_ctrl) exp_rd = m_en;
        else if (cs_table && reg_addr == 0) exp_rd = m_idx;
      end
      if (wr_en && cs_ctrl) m_en = wr_data[0];
      if (wr_en && cs_table) begin
        case (reg_addr)
          2'd0: m_idx = wr_data[3:0];
          2'd1: tbl[m_idx] = (tbl[m_idx] & 'hF00) | wr_data;
          2'd2: tbl[m_idx] = (tbl[m_idx] & 'h0FF) | (int'(wr_data[3:0]) << 8);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", req, phase, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (exp_valid) begin
      chk("R2", int'(phys_addr[11:0]), exp_phys & 'hFFF);
      chk(exp_rst ? "R6" : (exp_on ? "R1" : "R3"), int'(phys_addr[23:12]), exp_phys >> 12);
      chk(exp_rst ? "R6" : "R7", int'(rd_data), exp_rd);
    end
  end

  task automatic reg_wr(input bit tsel, input bit csel, input int off, input int d);
    @(negedge clk);
    wr_en = 1; cs_table = tsel; cs_ctrl = csel; reg_addr = off[1:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 0; cs_table = 0; cs_ctrl = 0;
  endtask

  task automatic reg_rd(input bit tsel, input bit csel, input int off);
    @(negedge clk);
    rd_en = 1; cs_table = tsel; cs_ctrl = csel; reg_addr = off[1:0];
    @(negedge clk);
    rd_en = 0; cs_table = 0; cs_ctrl = 0;
  endtask

  task automatic set_entry(input int i, input int v);
    reg_wr(1, 0, 0, i);
    reg_wr(1, 0, 1, v & 'hFF);
    reg_wr(1, 0, 2, (v >> 8) & 'hF);
  endtask

  task automatic sweep(input int n, input int seed);
    int s;
    s = seed;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s = (s * 1103515245 + 12345) & 'h7FFFFFFF;
      log_addr = s[23:8];
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    phase = "R3";
    sweep(20, 7);
    phase = "R4";
    for (int i = 0; i < 16; i++) set_entry(i, (i * 'h1A3 + 'h05C) & 'hFFF);
    set_entry(5, 'hABC);
    set_entry(15, 'hFFF);
    set_entry(0, 'h000);
    reg_wr(1, 0, 0, 3);
    reg_wr(1, 0, 1, 'h5A);          // low byte only, high nibble kept
    reg_wr(1, 0, 0, 4);
    reg_wr(1, 0, 2, 'hF7);          // high nibble only, upper data bits unused
    phase = "R5";
    reg_wr(0, 1, 2, 'hFE);          // bit 0 clear: stays disabled
    sweep(10, 3);
    reg_wr(0, 1, 0, 'h01);
    phase = "R1";
    sweep(40, 11);
    phase = "R8";
    @(negedge clk); cs_table = 1; reg_addr = 1; wr_data = 'h33; // no strobe
    @(negedge clk); cs_table = 0;
    reg_wr(1, 0, 3, 'h77);          // unused offset
    @(negedge clk); wr_en = 1; wr_data = 'h00; // strobe without select
    @(negedge clk); wr_en = 0;
    sweep(20, 19);
    phase = "R9";
    @(negedge clk); log_addr = 16'h5123; wr_en = 1; cs_ctrl = 1; wr_data = 0;
    @(negedge clk); wr_en = 0; cs_ctrl = 0;
    reg_wr(0, 1, 0, 1);
    @(negedge clk); log_addr = 16'h9FFF; wr_en = 1; cs_table = 1; reg_addr = 0; wr_data = 9;
    @(negedge clk); wr_en = 1; reg_addr = 1; wr_data = 'h11;
    @(negedge clk); wr_en = 0; cs_table = 0;
    @(negedge clk);
    phase = "R7";
    reg_rd(0, 1, 0);
    reg_rd(1, 0, 0);
    reg_rd(1, 0, 1);
    reg_rd(1, 1, 0);
    phase = "R6";
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    sweep(10, 23);
    reg_rd(0, 1, 0);
    reg_wr(0, 1, 0, 1);
    phase = "R1";
    sweep(30, 29);
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule